// File: doc/BRIEF.md
# RTC Alarm Comparator with Per-Field Enables

This block holds an alarm for a real-time clock and compares it with the running calendar time. The time is kept elsewhere. It arrives as seven bytes: seconds, minutes, hours, weekday, date, month and year. A one-cycle `tick` strobe marks the cycle in which that time has just advanced. Each alarm byte carries a compare-enable flag in bit 7 and a 7-bit value in bits 6:0. A field whose flag is clear is a don't-care, so the host can match any subset of fields. Examples are "every day at 07:30:00" or "the 15th of each month at midnight".

The host writes alarm bytes into a shadow set. These writes do not reach the comparator until the host sets a commit bit. After a fixed transfer delay the whole shadow set is copied into the active set in one cycle. With `AUTO_CLEAR = 1` the commit bit returns to zero by itself once the copy is done. With `AUTO_CLEAR = 0` the bit stays set until the host writes it back to zero. A match on a tick sets a sticky pending flag, which drives the interrupt line. The host clears the flag by writing 1 to it.

Register addresses:
- 0 to 6: shadow alarm bytes, in the order seconds, minutes, hours, weekday, date, month, year.
- 7: commit control, bit 0.
- 8: status, bit 0 = pending.

Unused read bits return zero.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every shadow byte (addresses 0..6), the commit bit (address 7 bit 0), the pending bit (address 8 bit 0) and `irq` read 0. A write to addresses 0..6 stores all 8 bits and reads back unchanged.
- R2: An active field with bit 7 = 1 matches when its bits 6:0 equal bits 6:0 of the corresponding `now` byte. `now` byte i sits at bits 8i+7..8i, and index 0 is seconds. A field with bit 7 = 0 matches any time value.
- R3: The alarm is armed only when at least one active field has bit 7 set. With no field enabled the pending bit never sets, whatever the time.
- R4: Writing 1 to address 7 bit 0 while it reads 0 starts a transfer. The shadow set is copied into the active set XFER_CYCLES clock edges after the write edge. Until that copy, shadow writes have no effect on matching.
- R5: With AUTO_CLEAR = 1 the commit bit reads 0 once the copy has happened, and writing 0 to it has no effect. With AUTO_CLEAR = 0 it keeps reading 1 after the copy until the host writes 0 to address 7 bit 0.
- R6: When `tick` is high and all fields match an armed alarm, the pending bit and `irq` are 1 from the following clock edge onward.
- R7: Matching is evaluated only in cycles with `tick` high. A matching `now` held without `tick` never sets the pending bit.
- R8: Writing 1 to address 8 bit 0 clears the pending bit. A match on the same edge wins over the clear. `irq` always equals the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address for write and read |
| wdata | input | BW (8) | Write data |
| rdata | output | BW (8) | Read data for `addr` (combinational) |
| tick | input | 1 | One-cycle pulse: `now` has just been updated |
| now | input | NF*BW (56) | Current time bytes, seconds in the low byte |
| irq | output | 1 | Alarm interrupt, high while pending |

## Verification
The hardest state to reach from the ports is the window between a commit request and the copy. In that window the shadow set already holds new values but the comparator still uses the old ones. The bench programs one alarm and commits it. It then loads a different shadow set, starts a second commit, and issues a tick matching the new values on the very next edge, which must not fire. The bench also sweeps all 128 enable subsets. For each subset it presents the exact time and, for each field in turn, a time that differs only in that field, so the don't-care handling is covered field by field.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF          = 7,
  parameter int BW          = 8,
  parameter int AW          = 4,
  parameter int XFER_CYCLES = 4,
  parameter bit AUTO_CLEAR  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [BW-1:0]      wdata,
  output logic [BW-1:0]      rdata,
  input  logic               tick,
  input  logic [NF*BW-1:0]   now,
  output logic               irq
);
  localparam int VW = BW - 1;
  localparam int CW = $clog2(XFER_CYCLES + 1);
  localparam logic [AW-1:0] CTL_A = AW'(NF);
  localparam logic [AW-1:0] STS_A = AW'(NF + 1);

  logic [NF-1:0][BW-1:0] shd, act;
  logic [NF-1:0]         fld_ok, en;
  logic [CW-1:0]         cnt;
  logic                  upd, pend;

  wire ctl_wr = we && addr == CTL_A;
  wire sts_wr = we && addr == STS_A;
  wire start  = ctl_wr && wdata[0] && !upd;
  wire fire   = cnt == CW'(1);

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) shd[g] <= '0;
        else if (we && addr == AW'(g)) shd[g] <= wdata;

      assign en[g]     = act[g][VW];
      assign fld_ok[g] = !en[g] || act[g][VW-1:0] == now[g*BW +: VW];
    end
  endgenerate

  wire armed = |en;
  wire hit   = armed && &fld_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      upd <= 1'b0;
      act <= '0;
    end else begin
      if (start) cnt <= CW'(XFER_CYCLES);
      else if (cnt != '0) cnt <= cnt - CW'(1);
      if (fire) act <= shd;
      if (start) upd <= 1'b1;
      else if (AUTO_CLEAR) begin
        if (fire) upd <= 1'b0;
      end else if (ctl_wr && !wdata[0]) upd <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (tick && hit) pend <= 1'b1;
    else if (sts_wr && wdata[0]) pend <= 1'b0;

  assign irq = pend;

  always_comb begin
    rdata = '0;
    if (addr < AW'(NF)) rdata = shd[addr[$clog2(NF)-1:0]];
    else if (addr == CTL_A) rdata[0] = upd;
    else if (addr == STS_A) rdata[0] = pend;
  end

  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hit |=> pend);
  p_tick_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !pend |=> !pend);
  p_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !pend |=> !pend);
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(act));
  p_autoclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    AUTO_CLEAR && fire && !start |=> !upd);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !AUTO_CLEAR && upd && !ctl_wr |=> upd);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && wdata[0] && !(tick && hit) |=> !pend);
endmodule

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  localparam int XF = 4;
  logic clk = 0, rst_n = 0, we = 0, tick = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [55:0] now_v = 0;
  logic [7:0]  rd0, rd1;
  logic        irq0, irq1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [6:0] av [7];

  always #10 clk = ~clk;

  rtc_alarm_match #(.XFER_CYCLES(XF), .AUTO_CLEAR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rd0), .tick(tick), .now(now_v), .irq(irq0));
  rtc_alarm_match #(.XFER_CYCLES(XF), .AUTO_CLEAR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rd1), .tick(tick), .now(now_v), .irq(irq1));

  task automatic chk(input string tag, input logic [7:0] a, input logic [7:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  function automatic logic [55:0] tvec(input int flip);
    logic [55:0] t = '0;
    for (int k = 0; k < 7; k++)
      t[k*8 +: 8] = {1'b0, (k == flip) ? (av[k] ^ 7'h01) : av[k]};
    return t;
  endfunction

  task automatic commit();
    wr(7, 8'h01);
    repeat (XF) @(posedge clk);
    #1 addr = 7; #1;
    chk("R5 auto commit bit", rd0, 8'h00);
    chk("R5 sticky commit bit", rd1, 8'h01);
    wr(7, 8'h00); #1;
    chk("R5 sticky host clear", rd1, 8'h00);
  endtask

  task automatic probe(input logic [55:0] t, input logic e, input string tag);
    now_v = t; tick = 1;
    @(posedge clk); #1 tick = 0;
    chk(tag, {7'b0, irq0}, {7'b0, e});
    chk(tag, {7'b0, irq1}, {7'b0, e});
    addr = 8; #1;
    chk("R8 irq equals status", rd0, {7'b0, irq0});
    wr(8, 8'h01); #1;
    chk("R8 clear", {7'b0, irq0}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 9; a++) begin
      addr = 4'(a); #1;
      chk("R1 reset read u0", rd0, 8'h00);
      chk("R1 reset read u1", rd1, 8'h00);
    end
    chk("R1 reset irq", {6'b0, irq0, irq1}, 8'h00);
    rst_n = 1;
    @(posedge clk); #1;

    for (int k = 0; k < 7; k++) wr(4'(k), 8'(8'hA0 + k));
    for (int k = 0; k < 7; k++) begin
      addr = 4'(k); #1;
      chk("R1 readback", rd0, 8'(8'hA0 + k));
    end

    for (int m = 0; m < 128; m++) begin
      for (int k = 0; k < 7; k++) begin
        av[k] = 7'((m + k * 11 + 1) % 128);
        wr(4'(k), {m[k], av[k]});
      end
      commit();
      probe(tvec(-1), m != 0, "R2/R3 exact time");
      for (int k = 0; k < 7; k++)
        probe(tvec(k), (m != 0) && !m[k], "R2 field differs");
    end

    for (int k = 0; k < 7; k++) begin
      av[k] = 7'(k + 20);
      wr(4'(k), {1'b1, av[k]});
    end
    commit();
    now_v = tvec(-1);
    repeat (5) @(posedge clk);
    #1 chk("R7 no tick no fire", {7'b0, irq0}, 8'h00);
    tick = 1; @(posedge clk); #1 tick = 0;
    chk("R6 tick fires", {7'b0, irq0}, 8'h01);
    repeat (3) @(posedge clk);
    #1 chk("R6 pending sticky", {7'b0, irq1}, 8'h01);
    addr = 8; wdata = 8'h01; we = 1; tick = 1;
    @(posedge clk); #1 we = 0; tick = 0;
    chk("R8 set wins over clear", {7'b0, irq0}, 8'h01);
    wr(8, 8'h01);
    chk("R8 clear after", {7'b0, irq0}, 8'h00);

    for (int k = 0; k < 7; k++) wr(4'(k), {1'b1, 7'(av[k] + 7'd40)});
    probe(tvec(-1), 1'b1, "R4 shadow write no effect");
    wr(7, 8'h01);
    for (int k = 0; k < 7; k++) av[k] = 7'(av[k] + 7'd40);
    probe(tvec(-1), 1'b0, "R4 before copy old values");
    repeat (XF) @(posedge clk);
    #1 probe(tvec(-1), 1'b1, "R4 after copy new values");
    wr(7, 8'h00);

    for (int k = 0; k < 7; k++) wr(4'(k), 8'(av[k]));
    commit();
    probe(tvec(-1), 1'b0, "R3 none enabled");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule